// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address by taking one of six 16-bit segment base registers, shifting it four bits left and adding the offset. The sum wraps within the 1 MB space. Each access names its kind and, for data, the class of base register that produced the offset. The block then picks the segment the rules imply. An optional override can redirect plain data and string-source accesses to any of the six segments.

Two string index pointers, one for source and one for destination, live inside the block. A string access uses the matching pointer as its offset. After the access, that pointer moves by 1, 2 or 4 bytes. It counts up or down depending on the direction input. The physical address and the index of the segment actually used come out one clock after the access is presented.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment value × 16) + offset, taken modulo 2^20, so segment 1000H with offset F000H gives 1F000H, segment 1000H with offset 2000H gives 12000H, and FFFFH:FFFFH gives 0FFEFH.
- R2: `addr_valid` is high exactly in the cycle after a clock edge at which `acc_valid` was high. Without an access, `phys_addr` and `seg_sel` keep their last values.
- R3: An instruction fetch (`acc_kind` 0) always uses the code segment (`seg_sel` 0), whatever the override inputs say.
- R4: A data access (`acc_kind` 1) whose base class is stack pointer (`acc_base` 1) or frame pointer (`acc_base` 2), with no override, uses the stack segment (`seg_sel` 3).
- R5: A data access whose base class is general (`acc_base` 0 or 3), with no override, uses the data segment (`seg_sel` 1).
- R6: A string-destination access (`acc_kind` 3) always uses the extra segment (`seg_sel` 2), with the destination pointer as its offset, and ignores the override inputs.
- R7: A string-source access (`acc_kind` 2) uses the source pointer as its offset. It defaults to the data segment and honours an override.
- R8: With `ovr_en` high, a data or string-source access uses segment `ovr_sel` when that value is 0 to 5. The values 6 and 7 are ignored and the default applies. The segment numbering is 0 code, 1 data, 2 extra, 3 stack, 4 and 5 auxiliary.
- R9: After a string access, the pointer it used moves by 1, 2, 4 or 4 for `elem_size` 0, 1, 2 or 3. It is incremented when `dir_dec` is 0 and decremented when `dir_dec` is 1, wrapping in 16 bits.
- R10: `idx_wr_en` loads the pointer chosen by `idx_wr_dst` (0 source, 1 destination). A load takes priority over a step of the same pointer in the same cycle, and an access in that cycle uses the pointer value from before the load.
- R11: `seg_wr_en` writes `seg_wr_val` into segment `seg_wr_sel` (writes to 6 or 7 are dropped). An access in the same cycle uses the value held before the write.
- R12: After reset, all segments, both pointers, `phys_addr`, `seg_sel` and `addr_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 3 | Segment register to write |
| seg_wr_val | input | 16 | Value written to the segment register |
| idx_wr_en | input | 1 | String pointer load strobe |
| idx_wr_dst | input | 1 | Pointer to load: 0 source, 1 destination |
| idx_wr_val | input | 16 | Value loaded into the pointer |
| dir_dec | input | 1 | 0 increments the string pointers, 1 decrements them |
| elem_size | input | 2 | String element size code |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 string source, 3 string destination |
| acc_base | input | 2 | Data base class: 0/3 general, 1 stack pointer, 2 frame pointer |
| ovr_en | input | 1 | Segment override requested |
| ovr_sel | input | 3 | Override segment index |
| acc_offset | input | 16 | Offset for fetch and data accesses |
| phys_addr | output | 20 | Registered physical address |
| seg_sel | output | 3 | Registered index of the segment used |
| addr_valid | output | 1 | Address and segment index are fresh |
| src_ptr | output | 16 | Current string source pointer |
| dst_ptr | output | 16 | Current string destination pointer |

## Verification
The address, segment index and valid flag are each due one clock edge after the access is sampled. Pointer steps and loads, and segment writes, also show one edge after they are presented. The bench drives every input on a falling edge and samples one falling edge later, so exactly one rising edge lies between stimulus and check. Accesses that coincide with a segment write or a pointer load are checked against the old register value. A follow-up access then confirms the new value.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    SEG_CODE  = 3'd0,
    SEG_DATA  = 3'd1,
    SEG_EXTRA = 3'd2,
    SEG_STACK = 3'd3,
    SEG_AUX1  = 3'd4,
    SEG_AUX2  = 3'd5
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH   = 2'd0,
    ACC_DATA    = 2'd1,
    ACC_STR_SRC = 2'd2,
    ACC_STR_DST = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    BASE_GEN_A    = 2'd0,
    BASE_STACKPTR = 2'd1,
    BASE_FRAMEPTR = 2'd2,
    BASE_GEN_B    = 2'd3
  } base_cls_e;

  localparam int unsigned NUM_SEGS = 6;
  localparam int unsigned SEL_W    = 3;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned NSEG  = NUM_SEGS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [SEG_W-1:0]           wr_val,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic             hit;
      logic [SEG_W-1:0] nxt;

      always_comb begin
        hit = wr_en && (wr_sel == SEL_W'(g));
        nxt = hit ? wr_val : seg_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seg_q[g] <= '0;
        end else if (hit) begin
          seg_q[g] <= nxt;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  acc_kind_e        kind,
  input  base_cls_e        base,
  input  logic             ovr_en,
  input  logic [SEL_W-1:0] ovr_sel,
  output seg_id_e          sel
);

  seg_id_e dflt;
  logic    ovr_ok;
  logic    ovr_allowed;

  always_comb begin
    unique case (kind)
      ACC_FETCH:   dflt = SEG_CODE;
      ACC_STR_DST: dflt = SEG_EXTRA;
      ACC_STR_SRC: dflt = SEG_DATA;
      default: begin
        if (base == BASE_STACKPTR || base == BASE_FRAMEPTR) begin
          dflt = SEG_STACK;
        end else begin
          dflt = SEG_DATA;
        end
      end
    endcase
  end

  always_comb begin
    ovr_allowed = (kind == ACC_DATA) || (kind == ACC_STR_SRC);
    ovr_ok      = ovr_en && ovr_allowed && (ovr_sel < SEL_W'(NUM_SEGS));
    sel         = ovr_ok ? seg_id_e'(ovr_sel) : dflt;
  end

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned PHYS_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  offset,
  output logic [PHYS_W-1:0] phys
);

  localparam int unsigned SUM_W = PHYS_W + 1;

  logic [SUM_W-1:0] base_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    base_ext = SUM_W'({seg_val, {SHIFT{1'b0}}});
    off_ext  = SUM_W'(offset);
    sum      = base_ext + off_ext;
    phys     = sum[PHYS_W-1:0];
  end

endmodule

// File: rtl/str_ptr_unit.sv
module str_ptr_unit #(
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_dst,
  input  logic [OFF_W-1:0] wr_val,
  input  logic             step_src,
  input  logic             step_dst,
  input  logic             dir_dec,
  input  logic [1:0]       elem_size,
  output logic [OFF_W-1:0] src_q,
  output logic [OFF_W-1:0] dst_q
);

  localparam int unsigned NPTR = 2;

  logic [OFF_W-1:0]          step;
  logic [NPTR-1:0][OFF_W-1:0] q;

  always_comb begin
    unique case (elem_size)
      2'd0:    step = OFF_W'(1);
      2'd1:    step = OFF_W'(2);
      default: step = OFF_W'(4);
    endcase
  end

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic             ld;
      logic             adv;
      logic             en;
      logic [OFF_W-1:0] nxt;

      always_comb begin
        ld  = wr_en && (wr_dst == (g != 0));
        adv = (g == 0) ? step_src : step_dst;
        en  = ld || adv;
        if (ld) begin
          nxt = wr_val;
        end else if (dir_dec) begin
          nxt = q[g] - step;
        end else begin
          nxt = q[g] + step;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q[g] <= '0;
        end else if (en) begin
          q[g] <= nxt;
        end
      end
    end
  endgenerate

  assign src_q = q[0];
  assign dst_q = q[1];

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned PHYS_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [2:0]        seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_val,
  input  logic              idx_wr_en,
  input  logic              idx_wr_dst,
  input  logic [OFF_W-1:0]  idx_wr_val,
  input  logic              dir_dec,
  input  logic [1:0]        elem_size,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_base,
  input  logic              ovr_en,
  input  logic [2:0]        ovr_sel,
  input  logic [OFF_W-1:0]  acc_offset,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [2:0]        seg_sel,
  output logic              addr_valid,
  output logic [OFF_W-1:0]  src_ptr,
  output logic [OFF_W-1:0]  dst_ptr
);

  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
  seg_id_e                        sel_c;
  acc_kind_e                      kind_c;
  base_cls_e                      base_c;
  logic [OFF_W-1:0]               off_c;
  logic [SEG_W-1:0]               seg_val_c;
  logic [PHYS_W-1:0]              phys_c;
  logic                           step_src;
  logic                           step_dst;
  logic [PHYS_W-1:0]              phys_nxt;
  logic [2:0]                     sel_nxt;

  seg_regfile #(
    .SEG_W (SEG_W),
    .NSEG  (NUM_SEGS)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (seg_wr_en),
    .wr_sel (seg_wr_sel),
    .wr_val (seg_wr_val),
    .seg_q  (seg_q)
  );

  always_comb begin
    kind_c = acc_kind_e'(acc_kind);
    base_c = base_cls_e'(acc_base);
  end

  seg_select u_sel (
    .kind    (kind_c),
    .base    (base_c),
    .ovr_en  (ovr_en),
    .ovr_sel (ovr_sel),
    .sel     (sel_c)
  );

  always_comb begin
    step_src = acc_valid && (kind_c == ACC_STR_SRC);
    step_dst = acc_valid && (kind_c == ACC_STR_DST);
    unique case (kind_c)
      ACC_STR_SRC: off_c = src_ptr;
      ACC_STR_DST: off_c = dst_ptr;
      default:     off_c = acc_offset;
    endcase
    seg_val_c = seg_q[sel_c];
  end

  str_ptr_unit #(
    .OFF_W (OFF_W)
  ) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (idx_wr_en),
    .wr_dst    (idx_wr_dst),
    .wr_val    (idx_wr_val),
    .step_src  (step_src),
    .step_dst  (step_dst),
    .dir_dec   (dir_dec),
    .elem_size (elem_size),
    .src_q     (src_ptr),
    .dst_q     (dst_ptr)
  );

  addr_adder #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT),
    .PHYS_W (PHYS_W)
  ) u_add (
    .seg_val (seg_val_c),
    .offset  (off_c),
    .phys    (phys_c)
  );

  always_comb begin
    phys_nxt = acc_valid ? phys_c : phys_addr;
    sel_nxt  = acc_valid ? 3'(sel_c) : seg_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      seg_sel    <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= acc_valid;
      if (acc_valid) begin
        phys_addr <= phys_nxt;
        seg_sel   <= sel_nxt;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned PHYS_W = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idx_wr_en,
  input logic              idx_wr_dst,
  input logic              dir_dec,
  input logic [1:0]        elem_size,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic [1:0]        acc_base,
  input logic              ovr_en,
  input logic [2:0]        ovr_sel,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [2:0]        seg_sel,
  input logic              addr_valid,
  input logic [OFF_W-1:0]  src_ptr,
  input logic [OFF_W-1:0]  dst_ptr
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> addr_valid); // R2

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !addr_valid); // R2

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(phys_addr) && $stable(seg_sel)); // R2

  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0) |=> seg_sel == 3'd0); // R3

  AST_STACK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd1 && !ovr_en && (acc_base == 2'd1 || acc_base == 2'd2))
      |=> seg_sel == 3'd3); // R4

  AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd1 && !ovr_en && (acc_base == 2'd0 || acc_base == 2'd3))
      |=> seg_sel == 3'd1); // R5

  AST_DST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd3) |=> seg_sel == 3'd2); // R6

  AST_OVR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind[0] != acc_kind[1] && ovr_en && ovr_sel < 3'd6)
      |=> seg_sel == $past(ovr_sel)); // R8

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> seg_sel < 3'd6); // R8

  AST_SRC_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd2 && !idx_wr_en && !dir_dec && elem_size == 2'd0)
      |=> src_ptr == OFF_W'($past(src_ptr) + OFF_W'(1))); // R9

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_valid && acc_kind == 2'd2) && !(idx_wr_en && !idx_wr_dst))
      |=> $stable(src_ptr)); // R10

  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_valid && acc_kind == 2'd3) && !(idx_wr_en && idx_wr_dst))
      |=> $stable(dst_ptr)); // R10

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W  (SEG_W),
  .OFF_W  (OFF_W),
  .SHIFT  (SHIFT),
  .PHYS_W (PHYS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idx_wr_en  (idx_wr_en),
  .idx_wr_dst (idx_wr_dst),
  .dir_dec    (dir_dec),
  .elem_size  (elem_size),
  .acc_valid  (acc_valid),
  .acc_kind   (acc_kind),
  .acc_base   (acc_base),
  .ovr_en     (ovr_en),
  .ovr_sel    (ovr_sel),
  .phys_addr  (phys_addr),
  .seg_sel    (seg_sel),
  .addr_valid (addr_valid),
  .src_ptr    (src_ptr),
  .dst_ptr    (dst_ptr)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        seg_wr_en;
  logic [2:0]  seg_wr_sel;
  logic [15:0] seg_wr_val;
  logic        idx_wr_en;
  logic        idx_wr_dst;
  logic [15:0] idx_wr_val;
  logic        dir_dec;
  logic [1:0]  elem_size;
  logic        acc_valid;
  logic [1:0]  acc_kind;
  logic [1:0]  acc_base;
  logic        ovr_en;
  logic [2:0]  ovr_sel;
  logic [15:0] acc_offset;
  logic [19:0] phys_addr;
  logic [2:0]  seg_sel;
  logic        addr_valid;
  logic [15:0] src_ptr;
  logic [15:0] dst_ptr;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  logic [15:0] segm [6];

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_val(seg_wr_val),
    .idx_wr_en(idx_wr_en), .idx_wr_dst(idx_wr_dst), .idx_wr_val(idx_wr_val),
    .dir_dec(dir_dec), .elem_size(elem_size),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_base(acc_base),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .acc_offset(acc_offset),
    .phys_addr(phys_addr), .seg_sel(seg_sel), .addr_valid(addr_valid),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {kind[2], base[2], ovr_en, ovr_sel[3], offset[16], exp_sel[3]}
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 3'd0, 16'hF000, 3'd0},  // R1 R3
    {2'd0, 2'd0, 1'b0, 3'd0, 16'h2000, 3'd0},  // R1 R3
    {2'd0, 2'd1, 1'b1, 3'd3, 16'h0040, 3'd0},  // R3 override ignored
    {2'd1, 2'd0, 1'b0, 3'd0, 16'h1234, 3'd1},  // R5
    {2'd1, 2'd1, 1'b0, 3'd0, 16'h0010, 3'd3},  // R4 stack pointer
    {2'd1, 2'd2, 1'b0, 3'd0, 16'h0FFE, 3'd3},  // R4 frame pointer
    {2'd1, 2'd3, 1'b0, 3'd0, 16'hABCD, 3'd1},  // R5
    {2'd1, 2'd1, 1'b1, 3'd5, 16'h0001, 3'd5},  // R8
    {2'd1, 2'd0, 1'b1, 3'd4, 16'hFFFF, 3'd4},  // R1 wrap, R8
    {2'd1, 2'd1, 1'b1, 3'd6, 16'h0002, 3'd3},  // R8 ignored code
    {2'd1, 2'd0, 1'b1, 3'd7, 16'h0003, 3'd1},  // R8 ignored code
    {2'd1, 2'd2, 1'b1, 3'd2, 16'h0004, 3'd2},  // R8
    {2'd1, 2'd0, 1'b1, 3'd0, 16'h0005, 3'd0}   // R8
  };

  function automatic logic [19:0] model_addr(input logic [2:0] s, input logic [15:0] off);
    logic [20:0] sum;
    sum = {1'b0, segm[s], 4'h0} + {5'h0, off};
    return sum[19:0];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wseg(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_val = v;
    @(negedge clk);
    seg_wr_en = 1'b0;
    if (s < 3'd6) segm[s] = v;
  endtask

  task automatic widx(input logic d, input logic [15:0] v);
    @(negedge clk);
    idx_wr_en = 1'b1; idx_wr_dst = d; idx_wr_val = v;
    @(negedge clk);
    idx_wr_en = 1'b0;
  endtask

  task automatic acc(input logic [1:0] k, input logic [1:0] b, input logic oe,
                     input logic [2:0] os, input logic [15:0] off);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_base = b; ovr_en = oe; ovr_sel = os; acc_offset = off;
    @(negedge clk);
    acc_valid = 1'b0; ovr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    seg_wr_en = 0; seg_wr_sel = 0; seg_wr_val = 0;
    idx_wr_en = 0; idx_wr_dst = 0; idx_wr_val = 0;
    dir_dec = 0; elem_size = 0;
    acc_valid = 0; acc_kind = 0; acc_base = 0; ovr_en = 0; ovr_sel = 0; acc_offset = 0;
    for (int i = 0; i < 6; i++) segm[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk("R12", "phys_addr", 32'(phys_addr), 0);
    chk("R12", "addr_valid", 32'(addr_valid), 0);
    chk("R12", "seg_sel", 32'(seg_sel), 0);
    chk("R12", "src_ptr", 32'(src_ptr), 0);
    chk("R12", "dst_ptr", 32'(dst_ptr), 0);
    rst_n = 1'b1;
    // R12: segment reset value seen through an access
    acc(2'd1, 2'd0, 1'b0, 3'd0, 16'h0777);
    chk("R12", "phys after reset", 32'(phys_addr), 32'h00777);

    wseg(3'd0, 16'h1000);
    wseg(3'd1, 16'h2000);
    wseg(3'd2, 16'h3000);
    wseg(3'd3, 16'h4000);
    wseg(3'd4, 16'hFFFF);
    wseg(3'd5, 16'h0ABC);
    wseg(3'd6, 16'h5555);  // R11 dropped write

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      acc(v[26:25], v[24:23], v[22], v[21:19], v[18:3]);
      chk("R2", "addr_valid", 32'(addr_valid), 1);
      chk("R3-R5/R8 vec", "seg_sel", 32'(seg_sel), 32'(v[2:0]));
      chk("R1", "phys_addr", 32'(phys_addr), 32'(model_addr(v[2:0], v[18:3])));
    end
    chk("R1", "1000:F000", 32'(model_addr(3'd0, 16'hF000)), 32'h1F000);

    // R2 hold with no access
    @(negedge clk);
    chk("R2", "valid idle", 32'(addr_valid), 0);
    chk("R2", "phys hold", 32'(phys_addr), 32'(model_addr(3'd0, 16'h0005)));

    // R7 R9 string source, increment by 2
    widx(1'b0, 16'h0100);
    widx(1'b1, 16'h0200);
    dir_dec = 1'b0; elem_size = 2'd1;
    acc(2'd2, 2'd0, 1'b0, 3'd0, 16'hDEAD);
    chk("R7", "src seg", 32'(seg_sel), 1);
    chk("R7", "src phys", 32'(phys_addr), 32'h20100);
    chk("R9", "src step +2", 32'(src_ptr), 32'h0102);
    chk("R9", "dst untouched", 32'(dst_ptr), 32'h0200);

    // R6 R9 string destination with ignored override, decrement by 4
    dir_dec = 1'b1; elem_size = 2'd2;
    acc(2'd3, 2'd0, 1'b1, 3'd4, 16'hBEEF);
    chk("R6", "dst seg", 32'(seg_sel), 2);
    chk("R6", "dst phys", 32'(phys_addr), 32'h30200);
    chk("R9", "dst step -4", 32'(dst_ptr), 32'h01FC);
    chk("R9", "src untouched", 32'(src_ptr), 32'h0102);

    // R7 R8 R9 source override, size code 3 steps by 4
    dir_dec = 1'b0; elem_size = 2'd3;
    acc(2'd2, 2'd0, 1'b1, 3'd3, 16'h0);
    chk("R7", "src override seg", 32'(seg_sel), 3);
    chk("R7", "src override phys", 32'(phys_addr), 32'h40102);
    chk("R9", "src step code3", 32'(src_ptr), 32'h0106);

    // R9 wrap below zero
    widx(1'b0, 16'h0000);
    dir_dec = 1'b1; elem_size = 2'd0;
    acc(2'd2, 2'd0, 1'b0, 3'd0, 16'h0);
    chk("R9", "wrap phys", 32'(phys_addr), 32'h20000);
    chk("R9", "wrap ptr", 32'(src_ptr), 32'hFFFF);

    // R10 load beats step; access uses old pointer
    dir_dec = 1'b0;
    @(negedge clk);
    idx_wr_en = 1'b1; idx_wr_dst = 1'b1; idx_wr_val = 16'h0500;
    acc_valid = 1'b1; acc_kind = 2'd3; acc_base = 2'd0; ovr_en = 1'b0;
    @(negedge clk);
    idx_wr_en = 1'b0; acc_valid = 1'b0;
    chk("R10", "old ptr used", 32'(phys_addr), 32'h301FC);
    chk("R10", "load wins", 32'(dst_ptr), 32'h0500);

    // R11 write with same-cycle access uses old segment
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 3'd1; seg_wr_val = 16'h5000;
    acc_valid = 1'b1; acc_kind = 2'd1; acc_base = 2'd0; acc_offset = 16'h0000;
    @(negedge clk);
    seg_wr_en = 1'b0; acc_valid = 1'b0;
    chk("R11", "old segment used", 32'(phys_addr), 32'h20000);
    segm[1] = 16'h5000;
    acc(2'd1, 2'd0, 1'b0, 3'd0, 16'h0000);
    chk("R11", "new segment used", 32'(phys_addr), 32'h50000);
    // R11 dropped write left the auxiliary segment intact
    acc(2'd1, 2'd0, 1'b1, 3'd5, 16'h0000);
    chk("R11", "aux2 intact", 32'(phys_addr), 32'h0ABC0);

    // R1 top-of-space wrap with maximum segment and offset
    wseg(3'd0, 16'hFFFF);
    acc(2'd0, 2'd0, 1'b0, 3'd0, 16'hFFFF);
    chk("R1", "FFFF:FFFF", 32'(phys_addr), 32'h0FFEF);

    finish_run();
  end

endmodule